// File: doc/BRIEF.md
# Regulator enable and voltage-select controller

This block decides, for one output regulator, whether the rail is switched on and which 8-bit voltage code it should target. Control comes either straight from a configuration enable bit or from one of three external enable pins. In pin mode the block reacts to edges of the chosen pin and inserts programmable startup and shutdown delays. A roof/floor variant keeps the rail on permanently and uses the pin level to pick between a normal and a floor voltage code.

The external pins are asynchronous. Each one passes through a two-flop synchronizer before a single edge detector looks at the selected pin. The delays count in steps of `TICK_CYC` clock cycles, so a delay code N waits N·`TICK_CYC` cycles. The two outputs are registered.

Top module: `rail_en_ctrl`

## Requirements
- R1: While `cfg_enable` is 0, `rail_on` is 0 and `rail_vcode` is 0 one clock later, whatever the other inputs are.
- R2: With `cfg_enable`=1 and `cfg_pin_mode`=0, `rail_on` is 1 and `rail_vcode` equals `cfg_vcode` one clock after the inputs are applied.
- R3: In pin mode, `cfg_pin_sel` value 0 selects `en_pin[0]`, 1 selects `en_pin[1]`, 2 selects `en_pin[2]`, and the reserved value 3 selects `en_pin[0]`. Unselected pins have no effect on the outputs.
- R4: In pin mode without roof/floor, with delay codes 0, a high level on the selected pin gives `rail_on`=1 with `rail_vcode`=`cfg_vcode`, and a low level gives `rail_on`=0 with `rail_vcode`=0. The outputs follow a pin change on the 4th clock edge after it (two synchronizer stages, edge detect, output register).
- R5: With `cfg_roof_floor`=1 in pin mode, `rail_on` stays 1. `rail_vcode` is `cfg_vcode` while the pin state is high and `cfg_vfloor` while it is low.
- R6: A rising edge on the selected pin takes effect `cfg_up_dly`·`TICK_CYC` cycles later than with a code of 0. A falling edge takes effect `cfg_dn_dly`·`TICK_CYC` cycles later.
- R7: Changes made through `cfg_enable` or `cfg_pin_mode` reach the outputs one clock later, regardless of the delay codes.
- R8: Changing `cfg_pin_sel` directly between pins detects no edge, so the pin state is kept. When pin mode is entered from register control, the pin state is loaded from the current pin level, and later edges behave normally.
- R9: An opposite edge that arrives while a delay is pending cancels the pending action and starts the delay for the new direction. At most one action is ever pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Master enable bit |
| cfg_pin_mode | input | 1 | 1: pin-edge control, 0: direct bit control |
| cfg_pin_sel | input | 2 | Enable pin selector (3 reserved, acts as 0) |
| cfg_roof_floor | input | 1 | 1: pin picks normal/floor code instead of on/off |
| cfg_up_dly | input | 4 | Startup delay in ticks |
| cfg_dn_dly | input | 4 | Shutdown delay in ticks |
| cfg_vcode | input | 8 | Normal voltage code |
| cfg_vfloor | input | 8 | Floor voltage code |
| en_pin | input | 3 | Asynchronous external enable pins |
| rail_on | output | 1 | Regulator enable |
| rail_vcode | output | 8 | Active voltage code (0 while off) |

## Verification
Two functions of the delay engine can act in the same cycle: a delay still counting down, and a new edge of the opposite direction that arrives before the count ends. The bench lowers the selected pin with a long shutdown code and raises it again before the count runs out. The rail must stay on through the cycle in which the cancelled shutdown would have fired and also afterwards. A second collision, a selector change in the same period as a level difference on the new pin, is judged by the rail holding its state.

// File: rtl/rail_en_pkg.sv
// Shared types for the regulator enable controller.
// Assumes nothing beyond IEEE 1800-2017 packages.
package rail_en_pkg;

    // Kind of delayed action waiting in the timer.
    typedef enum logic [1:0] {
        PEND_NONE = 2'd0,
        PEND_UP   = 2'd1,
        PEND_DN   = 2'd2
    } pend_t;

endpackage

// File: rtl/rail_en_sync.sv
// Two-flop synchronizer bank, one chain per asynchronous pin.
// Assumes the pins are quasi-static relative to the clock (enable pins).
module rail_en_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    for (genvar i = 0; i < W; i++) begin : g_chain
        // Two register stages per pin to settle metastability.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q[i] <= 1'b0;
                sync_q[i] <= 1'b0;
            end else begin
                meta_q[i] <= d[i];
                sync_q[i] <= meta_q[i];
            end
        end
    end

    assign q = sync_q;

endmodule

// File: rtl/rail_en_edge.sv
// Picks the controlling pin and detects its edges.
// Assumes synchronized inputs. A selector change or register-control period
// re-seeds the level history, so no edge is reported on the new pin.
module rail_en_edge #(
    parameter int NPIN = 3,
    parameter int SELW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pins_s,
    input  logic [SELW-1:0] sel,
    input  logic            pin_mode,
    output logic            level,
    output logic            rise,
    output logic            fall
);

    logic [SELW-1:0] sel_idx;
    logic [SELW-1:0] sel_q;
    logic            lvl_q;
    logic            same_pin;

    // Map reserved selector codes onto the first pin.
    always_comb begin
        if (int'(sel) >= NPIN) sel_idx = '0;
        else                   sel_idx = sel;
    end

    assign level    = pins_s[sel_idx];
    assign same_pin = (sel_idx == sel_q);

    // Edge flags are qualified by pin mode and an unchanged selection.
    always_comb begin
        rise = pin_mode && same_pin &&  level && !lvl_q;
        fall = pin_mode && same_pin && !level &&  lvl_q;
    end

    // Remember the previous level and the selection it belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            lvl_q <= 1'b0;
        end else begin
            sel_q <= sel_idx;
            lvl_q <= level;
        end
    end

endmodule

// File: rtl/rail_en_timer.sv
// Holds the delayed pin state and counts the startup/shutdown delays.
// Assumes TICK_CYC >= 1. A code of 0 applies the edge in the cycle it is
// seen. An opposite edge replaces a pending action (a newest-edge-wins rule).
module rail_en_timer
    import rail_en_pkg::*;
#(
    parameter int DW       = 4,
    parameter int TICK_CYC = 100000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          track,
    input  logic          level,
    input  logic          rise,
    input  logic          fall,
    input  logic [DW-1:0] up_code,
    input  logic [DW-1:0] dn_code,
    output logic          pin_on,
    output logic          pend_up,
    output logic          pend_dn
);

    localparam int TW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
    localparam logic [TW-1:0] TICK_LAST = TW'(TICK_CYC - 1);

    pend_t         pend_q;
    logic [TW-1:0] tick_q;
    logic [DW-1:0] steps_q;
    logic          on_q;

    // State and countdown update; edges take priority over expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_q    <= 1'b0;
            pend_q  <= PEND_NONE;
            tick_q  <= '0;
            steps_q <= '0;
        end else if (track) begin
            on_q    <= level;
            pend_q  <= PEND_NONE;
            tick_q  <= '0;
        end else if (rise) begin
            tick_q <= '0;
            if (up_code == '0) begin
                on_q   <= 1'b1;
                pend_q <= PEND_NONE;
            end else begin
                pend_q  <= PEND_UP;
                steps_q <= up_code;
            end
        end else if (fall) begin
            tick_q <= '0;
            if (dn_code == '0) begin
                on_q   <= 1'b0;
                pend_q <= PEND_NONE;
            end else begin
                pend_q  <= PEND_DN;
                steps_q <= dn_code;
            end
        end else if (pend_q != PEND_NONE) begin
            if (tick_q == TICK_LAST) begin
                tick_q <= '0;
                if (steps_q == DW'(1)) begin
                    on_q   <= (pend_q == PEND_UP);
                    pend_q <= PEND_NONE;
                end else begin
                    steps_q <= steps_q - DW'(1);
                end
            end else begin
                tick_q <= tick_q + TW'(1);
            end
        end
    end

    assign pin_on  = on_q;
    assign pend_up = (pend_q == PEND_UP);
    assign pend_dn = (pend_q == PEND_DN);

endmodule

// File: rtl/rail_en_out.sv
// Resolves the control mode into the registered enable and voltage code.
// Assumes the pin state comes from rail_en_timer. The code is 0 while off.
module rail_en_out #(
    parameter int VW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_enable,
    input  logic          cfg_pin_mode,
    input  logic          cfg_roof_floor,
    input  logic          pin_on,
    input  logic [VW-1:0] cfg_vcode,
    input  logic [VW-1:0] cfg_vfloor,
    output logic          rail_on,
    output logic [VW-1:0] rail_vcode
);

    logic          on_d;
    logic [VW-1:0] code_d;

    // Priority: master enable, then direct control, then the pin modes.
    always_comb begin
        if (!cfg_enable) begin
            on_d   = 1'b0;
            code_d = '0;
        end else if (!cfg_pin_mode) begin
            on_d   = 1'b1;
            code_d = cfg_vcode;
        end else if (cfg_roof_floor) begin
            on_d   = 1'b1;
            code_d = pin_on ? cfg_vcode : cfg_vfloor;
        end else begin
            on_d   = pin_on;
            code_d = pin_on ? cfg_vcode : '0;
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rail_on    <= 1'b0;
            rail_vcode <= '0;
        end else begin
            rail_on    <= on_d;
            rail_vcode <= code_d;
        end
    end

endmodule

// File: rtl/rail_en_ctrl.sv
// Top level: regulator enable and voltage-select controller.
// Assumes en_pin is asynchronous and all cfg_* inputs are synchronous to clk.
module rail_en_ctrl #(
    parameter int NPIN     = 3,
    parameter int SELW     = 2,
    parameter int DW       = 4,
    parameter int VW       = 8,
    parameter int TICK_CYC = 100000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_enable,
    input  logic            cfg_pin_mode,
    input  logic [SELW-1:0] cfg_pin_sel,
    input  logic            cfg_roof_floor,
    input  logic [DW-1:0]   cfg_up_dly,
    input  logic [DW-1:0]   cfg_dn_dly,
    input  logic [VW-1:0]   cfg_vcode,
    input  logic [VW-1:0]   cfg_vfloor,
    input  logic [NPIN-1:0] en_pin,
    output logic            rail_on,
    output logic [VW-1:0]   rail_vcode
);

    logic [NPIN-1:0] pins_s;
    logic            pin_mode;
    logic            sel_level;
    logic            edge_rise;
    logic            edge_fall;
    logic            pin_on;
    logic            pend_up;
    logic            pend_dn;

    assign pin_mode = cfg_enable && cfg_pin_mode;

    rail_en_sync #(.W(NPIN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (en_pin),
        .q     (pins_s)
    );

    rail_en_edge #(.NPIN(NPIN), .SELW(SELW)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins_s   (pins_s),
        .sel      (cfg_pin_sel),
        .pin_mode (pin_mode),
        .level    (sel_level),
        .rise     (edge_rise),
        .fall     (edge_fall)
    );

    rail_en_timer #(.DW(DW), .TICK_CYC(TICK_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .track   (!pin_mode),
        .level   (sel_level),
        .rise    (edge_rise),
        .fall    (edge_fall),
        .up_code (cfg_up_dly),
        .dn_code (cfg_dn_dly),
        .pin_on  (pin_on),
        .pend_up (pend_up),
        .pend_dn (pend_dn)
    );

    rail_en_out #(.VW(VW)) u_out (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_enable     (cfg_enable),
        .cfg_pin_mode   (cfg_pin_mode),
        .cfg_roof_floor (cfg_roof_floor),
        .pin_on         (pin_on),
        .cfg_vcode      (cfg_vcode),
        .cfg_vfloor     (cfg_vfloor),
        .rail_on        (rail_on),
        .rail_vcode     (rail_vcode)
    );

endmodule

// File: rtl/rail_en_chk.sv
// Property checker for rail_en_ctrl, attached with bind below.
module rail_en_chk #(
    parameter int VW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_enable,
    input logic          cfg_pin_mode,
    input logic          cfg_roof_floor,
    input logic [VW-1:0] cfg_vcode,
    input logic [VW-1:0] cfg_vfloor,
    input logic          rail_on,
    input logic [VW-1:0] rail_vcode,
    input logic          pend_up,
    input logic          pend_dn
);

    // R1: master enable low forces the rail off with code 0.
    a_r1_master_off: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> (!rail_on && rail_vcode == '0));

    // R2 and R7: direct control is on at the normal code one clock later.
    a_r2_direct_on: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && !cfg_pin_mode) |=> (rail_on && rail_vcode == $past(cfg_vcode)));

    // R5: roof/floor keeps the rail on with one of the two codes.
    a_r5_roof_floor_on: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && cfg_pin_mode && cfg_roof_floor) |=>
        (rail_on && (rail_vcode == $past(cfg_vcode) || rail_vcode == $past(cfg_vfloor))));

    // R9: never more than one delayed action waiting.
    a_r9_single_pending: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pend_up, pend_dn}));

    // R4: an off rail always reports code 0.
    a_r4_off_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rail_on |-> rail_vcode == '0 || (cfg_enable && cfg_pin_mode && cfg_roof_floor) || $past(cfg_enable && cfg_pin_mode && cfg_roof_floor));

endmodule

bind rail_en_ctrl rail_en_chk #(.VW(VW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_enable     (cfg_enable),
    .cfg_pin_mode   (cfg_pin_mode),
    .cfg_roof_floor (cfg_roof_floor),
    .cfg_vcode      (cfg_vcode),
    .cfg_vfloor     (cfg_vfloor),
    .rail_on        (rail_on),
    .rail_vcode     (rail_vcode),
    .pend_up        (pend_up),
    .pend_dn        (pend_dn)
);

// File: tb/sim_rail_en_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected outputs per cycle and the
// monitor compares them on the falling edge.
module sim_rail_en_ctrl;

    localparam int T = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_enable = 1'b0;
    logic       cfg_pin_mode = 1'b0;
    logic [1:0] cfg_pin_sel = 2'd0;
    logic       cfg_roof_floor = 1'b0;
    logic [3:0] cfg_up_dly = 4'd0;
    logic [3:0] cfg_dn_dly = 4'd0;
    logic [7:0] cfg_vcode = 8'h55;
    logic [7:0] cfg_vfloor = 8'h22;
    logic [2:0] en_pin = 3'b000;
    logic       rail_on;
    logic [7:0] rail_vcode;

    typedef struct {
        int         at;
        logic       en;
        logic [7:0] code;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    rail_en_ctrl #(.TICK_CYC(T)) u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_enable     (cfg_enable),
        .cfg_pin_mode   (cfg_pin_mode),
        .cfg_pin_sel    (cfg_pin_sel),
        .cfg_roof_floor (cfg_roof_floor),
        .cfg_up_dly     (cfg_up_dly),
        .cfg_dn_dly     (cfg_dn_dly),
        .cfg_vcode      (cfg_vcode),
        .cfg_vfloor     (cfg_vfloor),
        .en_pin         (en_pin),
        .rail_on        (rail_on),
        .rail_vcode     (rail_vcode)
    );

    task automatic expect_in(input int d, input logic en, input logic [7:0] code, input string tag);
        exp_t e;
        e.at = cyc + d;
        e.en = en;
        e.code = code;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare every item due in this cycle.
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].at == cyc) begin
                checks++;
                if (rail_on !== q[i].en || rail_vcode !== q[i].code) begin
                    errors++;
                    $display("FAIL %s: cycle %0d actual on=%b code=%h expected on=%b code=%h",
                             q[i].tag, cyc, rail_on, rail_vcode, q[i].en, q[i].code);
                end
                q.delete(i);
            end
        end
    end

    // Watchdog.
    initial begin
        #(5.0 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        expect_in(1, 1'b0, 8'h00, "R1 reset state");
        idle(3);

        // R1: everything else asserted, master enable low.
        cfg_pin_mode = 1'b1; cfg_roof_floor = 1'b1; en_pin = 3'b111;
        expect_in(1, 1'b0, 8'h00, "R1 ignored inputs");
        expect_in(6, 1'b0, 8'h00, "R1 ignored pins");
        idle(8);
        en_pin = 3'b000; cfg_roof_floor = 1'b0;
        idle(6);

        // R2: direct control.
        cfg_enable = 1'b1; cfg_pin_mode = 1'b0;
        expect_in(1, 1'b1, 8'h55, "R2 direct on");
        idle(3);
        cfg_vcode = 8'h60;
        expect_in(1, 1'b1, 8'h60, "R2 code change");
        idle(3);

        // R4: pin mode, pin 0 low.
        cfg_pin_sel = 2'd0; cfg_pin_mode = 1'b1;
        expect_in(1, 1'b0, 8'h00, "R4 pin mode entry low");
        idle(3);
        en_pin = 3'b001;
        expect_in(3, 1'b0, 8'h00, "R4 before latency");
        expect_in(4, 1'b1, 8'h60, "R4 high enables");
        idle(6);
        en_pin = 3'b011;
        expect_in(6, 1'b1, 8'h60, "R3 unselected pin ignored");
        idle(7);
        en_pin = 3'b010;
        expect_in(4, 1'b0, 8'h00, "R4 low disables");
        idle(6);

        // R8: switch to pin 1 (high) without an edge.
        cfg_pin_sel = 2'd1;
        expect_in(6, 1'b0, 8'h00, "R8 no edge on pin switch");
        idle(7);
        en_pin = 3'b000;
        idle(6);
        en_pin = 3'b010;
        expect_in(4, 1'b1, 8'h60, "R3 select 1 uses pin 1");
        idle(6);

        // Switch to pin 2 (low), state kept.
        cfg_pin_sel = 2'd2;
        expect_in(6, 1'b1, 8'h60, "R8 state kept on switch");
        idle(7);
        en_pin = 3'b110;
        idle(6);
        en_pin = 3'b010;
        expect_in(3, 1'b1, 8'h60, "R3 select 2 before latency");
        expect_in(4, 1'b0, 8'h00, "R3 select 2 uses pin 2");
        idle(6);

        // Reserved selector acts as pin 0.
        cfg_pin_sel = 2'd3;
        idle(6);
        en_pin = 3'b011;
        expect_in(4, 1'b1, 8'h60, "R3 reserved selector");
        idle(6);

        // R6: delays.
        cfg_pin_sel = 2'd0; cfg_up_dly = 4'd2; cfg_dn_dly = 4'd1;
        en_pin = 3'b010;
        expect_in(3 + T, 1'b1, 8'h60, "R6 shutdown not yet");
        expect_in(4 + T, 1'b0, 8'h00, "R6 shutdown delay");
        idle(4 + T + 2);
        en_pin = 3'b011;
        expect_in(3 + 2*T, 1'b0, 8'h00, "R6 startup not yet");
        expect_in(4 + 2*T, 1'b1, 8'h60, "R6 startup delay");
        idle(4 + 2*T + 2);

        // R9: rise cancels a pending shutdown.
        cfg_dn_dly = 4'd3;
        en_pin = 3'b010;
        expect_in(4 + 3*T, 1'b1, 8'h60, "R9 cancelled shutdown");
        expect_in(20, 1'b1, 8'h60, "R9 still on");
        idle(5);
        en_pin = 3'b011;
        idle(17);

        // R7: register control ignores delay codes.
        cfg_pin_mode = 1'b0;
        expect_in(1, 1'b1, 8'h60, "R7 direct immediate");
        idle(3);
        cfg_enable = 1'b0;
        expect_in(1, 1'b0, 8'h00, "R7 disable immediate");
        idle(3);
        cfg_enable = 1'b1;
        expect_in(1, 1'b1, 8'h60, "R7 enable immediate");
        idle(3);

        // R8: pin to register and back to the same pin.
        cfg_up_dly = 4'd0; cfg_dn_dly = 4'd0;
        cfg_pin_mode = 1'b1;
        expect_in(1, 1'b1, 8'h60, "R8 entry with pin high");
        idle(3);
        cfg_pin_mode = 1'b0;
        idle(2);
        en_pin = 3'b010;
        expect_in(6, 1'b1, 8'h60, "R8 register control holds");
        idle(7);
        cfg_pin_mode = 1'b1;
        expect_in(1, 1'b0, 8'h00, "R8 back to pin low");
        idle(3);
        en_pin = 3'b011;
        expect_in(4, 1'b1, 8'h60, "R8 edges work after return");
        idle(6);

        // R5: roof/floor.
        en_pin = 3'b010;
        expect_in(4, 1'b0, 8'h00, "R4 low again");
        idle(6);
        cfg_roof_floor = 1'b1;
        expect_in(1, 1'b1, 8'h22, "R5 floor code");
        idle(3);
        en_pin = 3'b011;
        expect_in(3, 1'b1, 8'h22, "R5 floor before latency");
        expect_in(4, 1'b1, 8'h60, "R5 roof code");
        idle(6);
        en_pin = 3'b010;
        expect_in(4, 1'b1, 8'h22, "R5 back to floor");
        idle(6);
        cfg_up_dly = 4'd2;
        en_pin = 3'b011;
        expect_in(3 + 2*T, 1'b1, 8'h22, "R6 roof delay pending");
        expect_in(4 + 2*T, 1'b1, 8'h60, "R6 roof after delay");
        idle(4 + 2*T + 2);
        cfg_enable = 1'b0;
        expect_in(1, 1'b0, 8'h00, "R1 off from roof/floor");
        idle(5);

        idle(5);
        done = 1'b1;
        if (q.size() != 0) begin
            errors++;
            checks++;
            $display("FAIL scoreboard: actual=%0d pending expected=0", q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule